// File: doc/BRIEF.md
# Timestamp-Matching Stream Pair Aligner

This block sits in the system clock domain behind two queues of time-stamped sensor records. One queue carries a fast inertial stream, at roughly one to four thousand records a second. The other carries a slow ranging stream, at tens of records a second. Every record holds a capture time taken from a single free-running 64-bit cycle counter that all sensors share, so the times from the two streams can be compared directly. One count is one fabric clock period.

The block looks at the head record of both queues. When the two capture times differ by no more than a tolerance supplied at run time, it sends the pair downstream as one two-beat AXI4-Stream frame. It pops both heads only after the final beat has been accepted. When the times differ by more than the tolerance, it pops and throws away whichever head is older, and then compares the next head. Because the slow stream is so much sparser, most fast records end up discarded. Three saturating counters report matched pairs, fast-side discards and slow-side discards. The queue heads are modelled as first-word-fall-through valid/data/pop ports, and a pop takes effect at the clock edge that ends the cycle in which it is high.

Top module: `ts_pair_aligner`

## Requirements
- R1: A record is REC_W = TS_W + PAY_W bits wide. The capture time sits in bits [REC_W-1:PAY_W] (upper 64 bits by default) and the payload in bits [PAY_W-1:0]. Only the capture time takes part in matching, and the output carries the records bit for bit.
- R2: While either head is absent (its valid is low) and no frame is in flight, the block pops nothing, starts no frame and leaves all counters unchanged.
- R3: Two heads match when |fast time − slow time| <= tolerance, with tolerance read in the cycle the comparison is made. A tolerance of zero matches only equal times, and a gap of tolerance+1 does not match.
- R4: A match produces a frame in the cycle after the comparison. Beat one carries the slow record with m_tlast = 0, and beat two carries the fast record with m_tlast = 1.
- R5: While m_tvalid is high and m_tready is low, m_tdata and m_tlast hold their values and m_tvalid stays high.
- R6: For a match, fast_pop and slow_pop rise together, for exactly one cycle, in the cycle where the second beat is accepted (m_tvalid, m_tlast and m_tready all high). Neither rises earlier in the frame.
- R7: On a mismatch, only the head with the smaller capture time is popped, in the comparison cycle itself. No output beat is produced, and at most one record is discarded per cycle.
- R8: pair_count, fast_drop_count and slow_drop_count each advance by one per matched pair, discarded fast record and discarded slow record respectively, and each stops at its all-ones value.
- R9: After reset, m_tvalid, fast_pop and slow_pop are low and all three counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tolerance | input | TS_W | Largest capture-time gap that still counts as a match |
| fast_valid | input | 1 | Fast-stream queue head present |
| fast_data | input | REC_W | Fast-stream head record {time, payload} |
| fast_pop | output | 1 | Remove the fast-stream head at this edge |
| slow_valid | input | 1 | Slow-stream queue head present |
| slow_data | input | REC_W | Slow-stream head record {time, payload} |
| slow_pop | output | 1 | Remove the slow-stream head at this edge |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream accepts the beat |
| m_tdata | output | REC_W | Output beat: slow record, then fast record |
| m_tlast | output | 1 | Marks the second beat of a frame |
| pair_count | output | CNT_W | Saturating count of matched pairs |
| fast_drop_count | output | CNT_W | Saturating count of discarded fast records |
| slow_drop_count | output | CNT_W | Saturating count of discarded slow records |

## Verification
The bench targets gaps placed exactly at the tolerance and one count past it, including tolerance zero with equal times. A design with an off-by-one compare would drop the first pair or fuse the second. Random back-pressure during frames shows whether the block pops the heads early, which loses records, or lets the beat data change while stalled. Directed phases with only one queue filled check that the block waits rather than discarding. A long run of unmatched fast records pushes the discard counter past its top value, which shows whether the counter wraps instead of saturating. Every output beat is compared with a pairing computed in the bench from the queue contents.

// File: rtl/tspa_pkg.sv
package tspa_pkg;

  // outcome of comparing the two queue heads
  typedef enum logic [1:0] {
    DEC_WAIT      = 2'd0,
    DEC_MATCH     = 2'd1,
    DEC_DROP_FAST = 2'd2,
    DEC_DROP_SLOW = 2'd3
  } pair_dec_e;

  // output frame progress
  typedef enum logic [1:0] {
    FR_IDLE   = 2'd0,
    FR_FIRST  = 2'd1,
    FR_SECOND = 2'd2
  } frame_st_e;

endpackage

// File: rtl/tspa_decider.sv
module tspa_decider #(
  parameter int TS_W = 64
) (
  input  logic            fast_valid,
  input  logic            slow_valid,
  input  logic [TS_W-1:0] fast_ts,
  input  logic [TS_W-1:0] slow_ts,
  input  logic [TS_W-1:0] tolerance,
  output tspa_pkg::pair_dec_e decision
);
  import tspa_pkg::*;

  // magnitude of the gap between two capture times
  function automatic logic [TS_W-1:0] ts_gap(input logic [TS_W-1:0] a,
                                             input logic [TS_W-1:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  // true when the fast record was captured first
  function automatic logic fast_is_older(input logic [TS_W-1:0] f,
                                         input logic [TS_W-1:0] s);
    return f < s;
  endfunction

  logic both_present;
  logic in_window;

  assign both_present = fast_valid && slow_valid;
  assign in_window    = ts_gap(fast_ts, slow_ts) <= tolerance;

  always_comb begin
    if (!both_present) begin
      decision = DEC_WAIT;
    end else if (in_window) begin
      decision = DEC_MATCH;
    end else if (fast_is_older(fast_ts, slow_ts)) begin
      decision = DEC_DROP_FAST;
    end else begin
      decision = DEC_DROP_SLOW;
    end
  end

endmodule

// File: rtl/tspa_framer.sv
module tspa_framer #(
  parameter int REC_W = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [REC_W-1:0] fast_rec,
  input  logic [REC_W-1:0] slow_rec,
  input  logic             m_tready,
  output logic             m_tvalid,
  output logic [REC_W-1:0] m_tdata,
  output logic             m_tlast,
  output logic             busy,
  output logic             done
);
  import tspa_pkg::*;

  frame_st_e        st;
  logic [REC_W-1:0] slow_q;
  logic [REC_W-1:0] fast_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= FR_IDLE;
      slow_q <= '0;
      fast_q <= '0;
    end else begin
      case (st)
        FR_IDLE: if (start) begin
          slow_q <= slow_rec;
          fast_q <= fast_rec;
          st     <= FR_FIRST;
        end
        FR_FIRST:  if (m_tready) st <= FR_SECOND;
        FR_SECOND: if (m_tready) st <= FR_IDLE;
        default:   st <= FR_IDLE;
      endcase
    end
  end

  assign m_tvalid = (st != FR_IDLE);
  assign m_tlast  = (st == FR_SECOND);
  assign m_tdata  = (st == FR_SECOND) ? fast_q : slow_q;
  assign busy     = m_tvalid;
  assign done     = (st == FR_SECOND) && m_tready;

  // R5: a stalled beat holds
  a_r5_beat_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

  // R4: an accepted first beat is followed by the last beat
  a_r4_second_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tready && !m_tlast) |=> (m_tvalid && m_tlast));

  // R4: a new frame opens with the non-last beat
  a_r4_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (m_tvalid && !m_tlast));

endmodule

// File: rtl/tspa_satcnt.sv
module tspa_satcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (inc && (count != TOP)) begin
      count <= count + W'(1);
    end
  end

  // R8: the top value is sticky
  a_r8_hold_top: assert property (@(posedge clk) disable iff (!rst_n)
    (count == TOP) |=> (count == TOP));

  // R8: below the top, each event adds one
  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && (count != TOP)) |=> (count == $past(count) + W'(1)));

endmodule

// File: rtl/ts_pair_aligner.sv
module ts_pair_aligner #(
  parameter int TS_W  = 64,
  parameter int PAY_W = 16,
  parameter int CNT_W = 32,
  localparam int REC_W = TS_W + PAY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TS_W-1:0]  tolerance,
  input  logic             fast_valid,
  input  logic [REC_W-1:0] fast_data,
  output logic             fast_pop,
  input  logic             slow_valid,
  input  logic [REC_W-1:0] slow_data,
  output logic             slow_pop,
  output logic             m_tvalid,
  input  logic             m_tready,
  output logic [REC_W-1:0] m_tdata,
  output logic             m_tlast,
  output logic [CNT_W-1:0] pair_count,
  output logic [CNT_W-1:0] fast_drop_count,
  output logic [CNT_W-1:0] slow_drop_count
);
  import tspa_pkg::*;

  localparam int NUM_CNT = 3;

  logic [TS_W-1:0] fast_ts;
  logic [TS_W-1:0] slow_ts;
  pair_dec_e       decision;
  logic            busy;
  logic            frame_done;
  logic            start_frame;
  logic            drop_fast_ev;
  logic            drop_slow_ev;

  assign fast_ts = fast_data[REC_W-1:PAY_W];
  assign slow_ts = slow_data[REC_W-1:PAY_W];

  tspa_decider #(.TS_W(TS_W)) u_decider (
    .fast_valid (fast_valid),
    .slow_valid (slow_valid),
    .fast_ts    (fast_ts),
    .slow_ts    (slow_ts),
    .tolerance  (tolerance),
    .decision   (decision)
  );

  // decisions are only acted on while no frame is in flight
  assign start_frame  = !busy && (decision == DEC_MATCH);
  assign drop_fast_ev = !busy && (decision == DEC_DROP_FAST);
  assign drop_slow_ev = !busy && (decision == DEC_DROP_SLOW);

  tspa_framer #(.REC_W(REC_W)) u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_frame),
    .fast_rec (fast_data),
    .slow_rec (slow_data),
    .m_tready (m_tready),
    .m_tvalid (m_tvalid),
    .m_tdata  (m_tdata),
    .m_tlast  (m_tlast),
    .busy     (busy),
    .done     (frame_done)
  );

  assign fast_pop = drop_fast_ev || frame_done;
  assign slow_pop = drop_slow_ev || frame_done;

  // event counters: 0 pairs, 1 fast discards, 2 slow discards
  logic [NUM_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0]   cnt_val [NUM_CNT];

  assign cnt_inc = {drop_slow_ev, drop_fast_ev, frame_done};

  for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
    tspa_satcnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (cnt_inc[gi]),
      .count (cnt_val[gi])
    );
  end

  assign pair_count      = cnt_val[0];
  assign fast_drop_count = cnt_val[1];
  assign slow_drop_count = cnt_val[2];

  // R2: an absent head means nothing is popped
  a_r2_wait_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_valid || !slow_valid) |-> (!fast_pop && !slow_pop));

  // R6: heads stay put until the last beat is taken
  a_r6_hold_heads: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !(m_tlast && m_tready)) |-> (!fast_pop && !slow_pop));

  // R6: a joint pop only on the accepted last beat
  a_r6_joint_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_pop && slow_pop) |-> (m_tvalid && m_tlast && m_tready));

  // R7: a lone fast pop discards the older record
  a_r7_fast_older: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_pop && !slow_pop) |-> (!m_tvalid && (fast_ts < slow_ts)));

  // R7: a lone slow pop discards the older record
  a_r7_slow_older: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_pop && !fast_pop) |-> (!m_tvalid && (slow_ts < fast_ts)));

  // R3: a match opens a frame on the next cycle
  a_r3_match_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_tvalid && fast_valid && slow_valid && !fast_pop && !slow_pop) |=> m_tvalid);

endmodule

// File: tb/test_ts_pair_aligner.sv
module test_ts_pair_aligner;
  localparam int TS_W  = 64;
  localparam int PAY_W = 16;
  localparam int REC_W = TS_W + PAY_W;
  localparam int CNT_W = 6;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [TS_W-1:0]  tolerance = '0;
  logic             fast_valid = 1'b0, slow_valid = 1'b0;
  logic [REC_W-1:0] fast_data = '0, slow_data = '0;
  logic             fast_pop, slow_pop;
  logic             m_tvalid, m_tlast;
  logic             m_tready = 1'b1;
  logic [REC_W-1:0] m_tdata;
  logic [CNT_W-1:0] pair_count, fast_drop_count, slow_drop_count;

  always #10 clk = ~clk;

  ts_pair_aligner #(.TS_W(TS_W), .PAY_W(PAY_W), .CNT_W(CNT_W)) i_ts_pair_aligner (
    .clk(clk), .rst_n(rst_n), .tolerance(tolerance),
    .fast_valid(fast_valid), .fast_data(fast_data), .fast_pop(fast_pop),
    .slow_valid(slow_valid), .slow_data(slow_data), .slow_pop(slow_pop),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast),
    .pair_count(pair_count), .fast_drop_count(fast_drop_count),
    .slow_drop_count(slow_drop_count)
  );

  int total = 0, bad = 0;
  logic [REC_W-1:0] fq[$], sq[$];
  logic [REC_W-1:0] got_d[$];
  logic             got_l[$];
  longint unsigned  f_ts[$], s_ts[$];
  int rdy_pct = 100;
  int exp_pair = 0, exp_fdrop = 0, exp_sdrop = 0;
  logic             prev_stall = 1'b0, prev_l = 1'b0;
  logic [REC_W-1:0] prev_d = '0;
  logic             last_fp = 1'b0, last_sp = 1'b0, last_tv = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [REC_W-1:0] act, input logic [REC_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [REC_W-1:0] mk(input longint unsigned ts, input int pay);
    logic [15:0] p;
    p = pay[15:0];
    return {ts, p};
  endfunction

  function automatic longint unsigned ts_of(input logic [REC_W-1:0] r);
    return r[REC_W-1:PAY_W];
  endfunction

  // window test written as two one-sided bounds (times stay far below overflow)
  function automatic bit close(input longint unsigned f, input longint unsigned s,
                               input longint unsigned tol);
    return (f <= s + tol) && (s <= f + tol);
  endfunction

  function automatic int sat_add(input int a, input int n);
    return (a + n > CMAX) ? CMAX : a + n;
  endfunction

  task automatic refresh();
    fast_valid = (fq.size() != 0);
    fast_data  = fast_valid ? fq[0] : '0;
    slow_valid = (sq.size() != 0);
    slow_data  = slow_valid ? sq[0] : '0;
    m_tready   = ($urandom_range(99) < rdy_pct);
  endtask

  task automatic tick();
    logic fp, sp, tv, tr, tl;
    logic [REC_W-1:0] td;
    @(negedge clk);
    fp = fast_pop; sp = slow_pop; tv = m_tvalid; tr = m_tready; tl = m_tlast; td = m_tdata;
    if (prev_stall)
      chk(tv && td == prev_d && tl == prev_l, "R5", "stalled beat changed", td, prev_d);
    if (!fast_valid || !slow_valid)
      chk(!fp && !sp, "R2", "pop with an absent head", {fp, sp}, '0);
    if ((fp || sp) && tv)
      chk(fp && sp && tl && tr, "R6", "pop before last beat accepted", {fp, sp, tl, tr}, 4'hF);
    if (fp != sp) begin
      chk(!tv, "R7", "discard during frame", tv, 0);
      if (fp) chk(ts_of(fast_data) < ts_of(slow_data), "R7", "fast popped not older",
                  ts_of(fast_data), ts_of(slow_data));
      else    chk(ts_of(slow_data) < ts_of(fast_data), "R7", "slow popped not older",
                  ts_of(slow_data), ts_of(fast_data));
    end
    if (tv && tr) begin
      got_d.push_back(td);
      got_l.push_back(tl);
    end
    prev_stall = tv && !tr; prev_d = td; prev_l = tl;
    last_fp = fp; last_sp = sp; last_tv = tv;
    @(posedge clk);
    #1;
    if (fp && fq.size() != 0) void'(fq.pop_front());
    if (sp && sq.size() != 0) void'(sq.pop_front());
    refresh();
  endtask

  task automatic check_counters(input string tag);
    chk(pair_count == CNT_W'(exp_pair), "R8", {tag, " pair_count"}, pair_count, exp_pair);
    chk(fast_drop_count == CNT_W'(exp_fdrop), "R8", {tag, " fast_drop_count"},
        fast_drop_count, exp_fdrop);
    chk(slow_drop_count == CNT_W'(exp_sdrop), "R8", {tag, " slow_drop_count"},
        slow_drop_count, exp_sdrop);
  endtask

  // run one phase on f_ts/s_ts with a fixed tolerance; compare with the bench pairing
  task automatic run_phase(input string tag, input longint unsigned tol);
    logic [REC_W-1:0] fr[$], sr[$], eb[$];
    int i, j, np, nf, ns, quiet, guard;
    foreach (f_ts[k]) fr.push_back(mk(f_ts[k], int'($urandom_range(16'hFFFF))));
    foreach (s_ts[k]) sr.push_back(mk(s_ts[k], int'($urandom_range(16'hFFFF))));
    i = 0; j = 0; np = 0; nf = 0; ns = 0;
    while (i < fr.size() && j < sr.size()) begin
      if (close(f_ts[i], s_ts[j], tol)) begin
        eb.push_back(sr[j]); eb.push_back(fr[i]); np++; i++; j++;
      end else if (f_ts[i] < s_ts[j]) begin nf++; i++; end
      else begin ns++; j++; end
    end
    got_d.delete(); got_l.delete();
    fq = fr; sq = sr; tolerance = tol;
    refresh();
    quiet = 0; guard = 0;
    while (quiet < 4 && guard < 20000) begin
      tick();
      guard++;
      if (last_fp || last_sp || last_tv) quiet = 0; else quiet++;
    end
    chk(got_d.size() == eb.size(), "R4", {tag, " beat count"}, got_d.size(), eb.size());
    for (int k = 0; k < got_d.size() && k < eb.size(); k++) begin
      chk(got_d[k] == eb[k], ((k % 2) == 0) ? "R1/R3 slow beat" : "R1/R3 fast beat",
          tag, got_d[k], eb[k]);
      chk(got_l[k] == (k % 2), "R4", {tag, " tlast position"}, got_l[k], k % 2);
    end
    exp_pair = sat_add(exp_pair, np);
    exp_fdrop = sat_add(exp_fdrop, nf);
    exp_sdrop = sat_add(exp_sdrop, ns);
    check_counters(tag);
    fq.delete(); sq.delete(); f_ts.delete(); s_ts.delete();
    refresh();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    refresh();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(!m_tvalid, "R9", "m_tvalid after reset", m_tvalid, 0);
    chk(!fast_pop && !slow_pop, "R9", "pops after reset", {fast_pop, slow_pop}, 0);
    check_counters("R9 reset");
    @(posedge clk); #1;

    // R2: one queue filled, the other empty -> nothing happens
    fq.push_back(mk(10, 1)); fq.push_back(mk(20, 2)); fq.push_back(mk(30, 3));
    refresh();
    repeat (8) tick();
    chk(fq.size() == 3, "R2", "fast records kept with slow empty", fq.size(), 3);
    chk(!m_tvalid, "R2", "no frame with slow empty", m_tvalid, 0);
    fq.delete(); sq.push_back(mk(5, 9)); refresh();
    repeat (8) tick();
    chk(sq.size() == 1, "R2", "slow record kept with fast empty", sq.size(), 1);
    check_counters("R2");
    sq.delete(); refresh();

    // R3: tolerance zero, exact equality required
    rdy_pct = 100;
    f_ts = '{90, 100}; s_ts = '{100};
    run_phase("R3 tol0", 0);

    // R3/R7: gap equal to tolerance matches, tolerance+1 discards (both sides)
    rdy_pct = 50;
    f_ts = '{195, 294, 306}; s_ts = '{200, 300};
    run_phase("R3 edge", 5);

    // R5/R6: heavy back-pressure on matched frames
    rdy_pct = 25;
    f_ts = '{1000, 1010, 1020}; s_ts = '{1002, 1011, 1024};
    run_phase("R5 stall", 4);

    // random phases
    for (int r = 0; r < 6; r++) begin
      longint unsigned t;
      rdy_pct = 40 + int'($urandom_range(60));
      t = 50 + $urandom_range(20);
      for (int k = 0; k < 40; k++) begin
        f_ts.push_back(t);
        t += 20 + $urandom_range(20);
      end
      for (int k = 0; k < 5; k++) s_ts.push_back(250 * (k + 1) + $urandom_range(12));
      run_phase("R3/R7 random", $urandom_range(15));
    end

    // R8: a long run of unmatched fast records drives the fast counter to its top
    rdy_pct = 100;
    for (int k = 0; k < 80; k++) f_ts.push_back(10 + 10 * k);
    s_ts = '{5000};
    run_phase("R8 saturate", 3);
    chk(fast_drop_count == CNT_W'(CMAX), "R8", "fast counter at top", fast_drop_count, CMAX);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule